// File: doc/BRIEF.md
# Clean-First LRU Victim Selector

This block is a recency-ordered directory for a small page buffer placed in front of storage where writes cost much more than reads. Each of its `N` slots holds a tag and a dirty bit. Slot 0 is the most recently used position. Occupied slots always form a contiguous run starting at slot 0. A request carries a tag and a read/write flag. A hit moves the entry to the MRU position. A miss inserts the tag at the MRU position, and when every slot is occupied it also pushes one entry out.

The `W` slots at the LRU end form a clean-first window. The rest of the list is the working region. On an eviction the selector takes the clean entry in the window that lies closest to the LRU end. Only when the window holds no clean entry does it evict the LRU entry, which is then dirty. The eviction reports the victim's tag and raises a writeback flag when the victim is dirty. The buffer data and the flush itself belong to the surrounding logic. With `W = N` the search covers the whole list.

Top module: `cf_lru_dir`

## Requirements
- R1: After reset the directory is empty, and `respValid`, `respHit`, `evictValid` and `evictWriteback` are 0 until a request is taken.
- R2: A request sampled with `reqValid=1` on a rising edge gets its response on the outputs after that same edge. The response stays for exactly one cycle, with `respValid=1`. `respValid` is 0 in cycles that follow no request.
- R3: A miss inserts `reqTag` at the MRU slot. The new entry is dirty when `reqWrite=1` and clean when `reqWrite=0`.
- R4: A hit sets `respHit=1` and moves the entry to the MRU slot. The entries that were more recent shift one place toward the LRU end. A hit never evicts.
- R5: A write hit marks the entry dirty. A read hit leaves the entry's dirty bit unchanged.
- R6: A miss while all `N` slots are occupied evicts one entry (`evictValid=1`, `evictTag`). If the `W` slots at the LRU end (slots `N-W` to `N-1`) hold a clean entry, the victim is the clean entry with the highest slot index among them.
- R7: If no entry in the window is clean, the entry in slot `N-1` is evicted.
- R8: `evictWriteback` is 1 exactly when the evicted entry is dirty, and never without `evictValid`.
- R9: Clean entries in the working region (slots 0 to `N-W-1`) are never chosen while the window holds only dirty entries.
- R10: A miss while free slots remain evicts nothing. The directory never holds the same tag twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqTag | input | TW | Tag of the requested page |
| respValid | output | 1 | Response for the previous cycle's request |
| respHit | output | 1 | The request hit |
| evictValid | output | 1 | An entry was evicted |
| evictWriteback | output | 1 | The evicted entry was dirty |
| evictTag | output | TW | Tag of the evicted entry |

## Verification
A wrong recency order, a lost dirty bit or a bad window bound stays hidden while the directory fills. It shows up only at the ports, and only when a later full-buffer miss reports a different victim tag or a different writeback flag. The delay can be as long as the time the faulty entry needs to drift into the window. The bench therefore keeps an independent ordered list model and runs long mixed read/write sequences over a tag space a little larger than `N`. This keeps the buffer full and forces frequent evictions, so a corrupted slot reaches an observable eviction within a few dozen requests. Directed fills also set up an all-dirty window with clean entries in the working region, and a window holding several clean entries.

// File: rtl/cf_lru_pkg.sv
package cf_lru_pkg;
  typedef struct packed {
    logic upd;      // shift the list and write the MRU slot
    logic isHit;    // the moved entry comes from a hit slot
    logic isWrite;  // request is a write
  } dirStrobe_t;
endpackage

// File: rtl/cf_lru_store.sv
module cf_lru_store
  import cf_lru_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 4,
  parameter int TW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic [TW-1:0] reqTag,
  input  dirStrobe_t    strobe,
  input  logic [IW-1:0] moveSlot,
  output logic          anyHit,
  output logic [IW-1:0] hitIdx,
  output logic [IW-1:0] freeIdx,
  output logic          full,
  output logic [IW-1:0] victimIdx,
  output logic          windowClean,
  output logic          victimDirty,
  output logic [TW-1:0] victimTag
);
  localparam int WinLo = N - W;

  logic [TW-1:0] tagQ   [N];
  logic [N-1:0]  dirtyQ;
  logic [N-1:0]  validQ;
  logic [N-1:0]  hitVec;
  logic          headDirty;

  // tag match
  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < N; i++) begin
      hitVec[i] = validQ[i] && (tagQ[i] == reqTag);
      if (hitVec[i]) begin
        anyHit = 1'b1;
        hitIdx = IW'(i);
      end
    end
  end

  // first free slot (lowest index)
  always_comb begin
    freeIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!validQ[i]) freeIdx = IW'(i);
    end
  end

  assign full = &validQ;

  // clean-first window search: last clean hit in ascending order is nearest LRU
  always_comb begin
    victimIdx   = IW'(N - 1);
    windowClean = 1'b0;
    for (int i = WinLo; i < N; i++) begin
      if (validQ[i] && !dirtyQ[i]) begin
        victimIdx   = IW'(i);
        windowClean = 1'b1;
      end
    end
  end

  assign victimDirty = dirtyQ[victimIdx];
  assign victimTag   = tagQ[victimIdx];
  assign headDirty   = (strobe.isHit ? dirtyQ[moveSlot] : 1'b0) | strobe.isWrite;

  // remove entry at moveSlot, shift more recent ones down, write slot 0
  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tagQ[0]   <= '0;
          dirtyQ[0] <= 1'b0;
          validQ[0] <= 1'b0;
        end else if (strobe.upd) begin
          tagQ[0]   <= reqTag;
          dirtyQ[0] <= headDirty;
          validQ[0] <= 1'b1;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tagQ[g]   <= '0;
          dirtyQ[g] <= 1'b0;
          validQ[g] <= 1'b0;
        end else if (strobe.upd && (IW'(g) <= moveSlot)) begin
          tagQ[g]   <= tagQ[g-1];
          dirtyQ[g] <= dirtyQ[g-1];
          validQ[g] <= validQ[g-1];
        end
      end
    end
  end

  // R10: tags stay unique, so at most one slot matches
  p_unique_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> $onehot0(hitVec));

  // R3: the MRU slot receives the request tag with the dirty state of the request
  p_insert_mru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.upd && !strobe.isHit) |=>
      (tagQ[0] == $past(reqTag)) && (dirtyQ[0] == $past(strobe.isWrite)) && validQ[0]);

  // R5: a write hit leaves the moved entry dirty
  p_write_hit_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.upd && strobe.isHit && strobe.isWrite) |=> dirtyQ[0]);

  // R6: the victim slot always lies inside the window
  p_victim_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (int'(victimIdx) >= WinLo));
endmodule

// File: rtl/cf_lru_ctrl.sv
module cf_lru_ctrl
  import cf_lru_pkg::*;
#(
  parameter int N  = 8,
  parameter int TW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic          anyHit,
  input  logic [IW-1:0] hitIdx,
  input  logic [IW-1:0] freeIdx,
  input  logic          full,
  input  logic [IW-1:0] victimIdx,
  input  logic          windowClean,
  input  logic          victimDirty,
  input  logic [TW-1:0] victimTag,
  output dirStrobe_t    strobe,
  output logic [IW-1:0] moveSlot,
  output logic          respValid,
  output logic          respHit,
  output logic          evictValid,
  output logic          evictWriteback,
  output logic [TW-1:0] evictTag
);
  logic doEvict;

  assign doEvict = reqValid && !anyHit && full;

  always_comb begin
    strobe.upd     = reqValid;
    strobe.isHit   = anyHit;
    strobe.isWrite = reqWrite;
    if (anyHit)    moveSlot = hitIdx;
    else if (full) moveSlot = victimIdx;
    else           moveSlot = freeIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid      <= 1'b0;
      respHit        <= 1'b0;
      evictValid     <= 1'b0;
      evictWriteback <= 1'b0;
      evictTag       <= '0;
    end else begin
      respValid      <= reqValid;
      respHit        <= reqValid && anyHit;
      evictValid     <= doEvict;
      evictWriteback <= doEvict && victimDirty;
      evictTag       <= doEvict ? victimTag : '0;
    end
  end

  // R8: writeback only accompanies an eviction
  p_wb_with_evict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evictWriteback |-> evictValid);

  // R4: a hit response never carries an eviction
  p_hit_no_evict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    respHit |-> (respValid && !evictValid));

  // R6: with a clean window entry, the eviction is clean
  p_clean_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !anyHit && full && windowClean) |=> (evictValid && !evictWriteback));

  // R7: an all-dirty window gives a dirty eviction
  p_dirty_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !anyHit && full && !windowClean) |=> (evictValid && evictWriteback));

  // R10: no eviction while free slots remain
  p_no_evict_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !full) |=> !evictValid);
endmodule

// File: rtl/cf_lru_dir.sv
module cf_lru_dir
  import cf_lru_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 4,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [TW-1:0] reqTag,
  output logic          respValid,
  output logic          respHit,
  output logic          evictValid,
  output logic          evictWriteback,
  output logic [TW-1:0] evictTag
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  dirStrobe_t    strobe;
  logic [IW-1:0] moveSlot, hitIdx, freeIdx, victimIdx;
  logic          anyHit, full, windowClean, victimDirty;
  logic [TW-1:0] victimTag;

  initial begin
    p_param_ok: assert (W >= 1 && W <= N && N >= 2);
  end

  cf_lru_store #(.N(N), .W(W), .TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqTag(reqTag),
    .strobe(strobe), .moveSlot(moveSlot), .anyHit(anyHit), .hitIdx(hitIdx),
    .freeIdx(freeIdx), .full(full), .victimIdx(victimIdx),
    .windowClean(windowClean), .victimDirty(victimDirty), .victimTag(victimTag)
  );

  cf_lru_ctrl #(.N(N), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .anyHit(anyHit), .hitIdx(hitIdx), .freeIdx(freeIdx), .full(full),
    .victimIdx(victimIdx), .windowClean(windowClean), .victimDirty(victimDirty),
    .victimTag(victimTag), .strobe(strobe), .moveSlot(moveSlot),
    .respValid(respValid), .respHit(respHit), .evictValid(evictValid),
    .evictWriteback(evictWriteback), .evictTag(evictTag)
  );
endmodule

// File: tb/cf_lru_dir_tb.sv
module cf_lru_dir_tb;
  localparam int N = 8;
  localparam int W = 4;
  localparam int TW = 8;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [TW-1:0] reqTag = '0;
  logic respValid, respHit, evictValid, evictWriteback;
  logic [TW-1:0] evictTag;

  int nVec = 0, nBad = 0, cycles = 0;
  bit done = 0;

  // reference list model: index 0 = MRU
  int mTag [N];
  bit mDirty [N];
  int mCnt = 0;

  always #(ClkPeriod/2) clk = ~clk;

  cf_lru_dir #(.N(N), .W(W), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqTag(reqTag), .respValid(respValid), .respHit(respHit),
    .evictValid(evictValid), .evictWriteback(evictWriteback), .evictTag(evictTag)
  );

  task automatic chk(string req, int got, int exp);
    nVec++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // move model entry at slot r to the front with given tag/dirty
  task automatic mMove(int r, int tag, bit d);
    for (int i = r; i > 0; i--) begin
      mTag[i] = mTag[i-1];
      mDirty[i] = mDirty[i-1];
    end
    mTag[0] = tag;
    mDirty[0] = d;
  endtask

  task automatic access(int tag, bit wr);
    int h = -1, v;
    bit eHit = 0, eEv = 0, eWb = 0;
    int eTag = 0;
    for (int i = 0; i < mCnt; i++) if (mTag[i] == tag) h = i;
    if (h >= 0) begin
      eHit = 1;
      mMove(h, tag, mDirty[h] | wr);
    end else if (mCnt < N) begin
      mMove(mCnt, tag, wr);
      mCnt++;
    end else begin
      v = N - 1;
      for (int i = N - W; i < N; i++) if (!mDirty[i]) v = i;
      eEv = 1; eWb = mDirty[v]; eTag = mTag[v];
      mMove(v, tag, wr);
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqTag = TW'(tag);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 respValid", int'(respValid), 1);
    chk(eHit ? "R4 respHit" : "R3 respHit", int'(respHit), int'(eHit));
    chk(eEv ? "R6 evictValid" : "R10 evictValid", int'(evictValid), int'(eEv));
    chk("R8 evictWriteback", int'(evictWriteback), int'(eWb));
    if (eEv) chk(eWb ? "R7 evictTag" : "R6 evictTag", int'(evictTag), eTag);
    @(negedge clk);
    chk("R2 respValid idle", int'(respValid), 0);
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mCnt = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nBad++;
        $display("FAIL watchdog got=%0d exp=<150000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    doReset();
    @(negedge clk);
    // R1: reset state
    chk("R1 respValid", int'(respValid), 0);
    chk("R1 respHit", int'(respHit), 0);
    chk("R1 evictValid", int'(evictValid), 0);
    chk("R1 evictWriteback", int'(evictWriteback), 0);

    // R9/R7: dirty window, clean working region -> LRU dirty evicted
    for (int t = 0; t < 4; t++) access(t, 1'b1);
    for (int t = 4; t < 8; t++) access(t, 1'b0);
    access(20, 1'b0);       // evicts tag 0, dirty (R9)
    chk("R9 model tag0 gone", mTag[N-1], 1);

    // R5: read hit keeps dirty, write hit dirties a clean entry
    doReset();
    for (int t = 0; t < 8; t++) access(t, t[0]);
    access(0, 1'b1);        // clean 0 becomes dirty at MRU (R5)
    access(1, 1'b0);        // dirty 1 stays dirty (R5)
    access(30, 1'b0);
    access(31, 1'b0);
    access(32, 1'b1);
    access(33, 1'b0);
    access(34, 1'b0);

    // R6: several clean entries in window, repeated evictions drain clean first
    doReset();
    for (int t = 0; t < 8; t++) access(40 + t, (t % 3) == 1);
    for (int t = 0; t < 6; t++) access(60 + t, 1'b0);

    // near-exhaustive mixed sweeps over small tag spaces
    for (int space = 9; space <= 14; space += 1) begin
      doReset();
      lfsr = 16'hACE1 ^ 16'(space);
      for (int k = 0; k < 1500; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        access(int'(lfsr[7:0]) % space, lfsr[9] & lfsr[3]);
      end
    end
    finishRun();
  end
endmodule